// File: doc/BRIEF.md
# Full-Duplex Serial Port with Two-Way Clear-To-Send Handshake

This block joins internal byte-wide logic to an external serial bridge over a two-wire asynchronous link. Bytes offered on the transmit valid/ready port are sent on `txd`. Characters arriving on `rxd` are checked and stored in a small receive FIFO, and they leave through the receive valid/ready port. The bit rate, the number of data bits and the number of stop bits are set by elaboration parameters only. No setting can be changed at runtime. With the default parameters a 24 MHz clock drives a 500000 baud line, which is 48 clocks per bit.

Flow control works in both directions. The peer raises `cts_in` to allow this side to transmit. The transmitter never starts a character while that permission is absent. A character that is already on the wire is always finished. This side drives `cts_out` low once its receive FIFO is close to full.

The transmitter has four states. `TX_IDLE` goes to `TX_START` when a byte is accepted. `TX_START` goes to `TX_DATA` after one bit time. `TX_DATA` goes to `TX_STOP` after the last data bit. `TX_STOP` returns to `TX_IDLE` after the last stop bit. The receiver also has four states. `RX_IDLE` goes to `RX_START` on a falling edge of the synchronised line. `RX_START` goes to `RX_DATA` if the line is still low at half a bit, and otherwise goes back to `RX_IDLE`. `RX_DATA` goes to `RX_STOP` after the last data sample. `RX_STOP` goes to `RX_IDLE` after the stop sample, and stores the byte at that point.

Top module: `uart_fc`

## Requirements
- R1: The idle line is high. Each character is one low start bit, then 8 data bits with the least significant bit first, then one high stop bit.
- R2: Every bit on `txd` lasts exactly CLK_HZ/BAUD clocks (48 by default), with no extra or missing clock at any bit boundary.
- R3: `tx_ready` is high only while the transmitter is idle and the synchronised `cts_in` is high. The start bit appears on `txd` in the cycle after the handshake. A start bit begins only if `cts_in` was high at a clock edge no more than two edges before the handshake edge.
- R4: If `cts_in` falls while a character is being sent, that character is still completed correctly. No further character starts while `cts_in` stays low.
- R5: `rxd` passes through a two-flop synchroniser. A falling edge is accepted as a start bit only if the line is still low half a bit later. A low pulse shorter than that yields no byte.
- R6: Received bytes are delivered in arrival order on `rx_data` with `rx_valid`. Data and flag stay stable while `rx_ready` is low.
- R7: `rx_frame_err` is 1 alongside a byte whose stop bit was sampled low, and 0 otherwise.
- R8: `cts_out` is high while the receive FIFO holds at most FIFO_DEPTH-2 bytes, and low when it holds more.
- R9: A byte that completes while the FIFO is full is discarded. The stored bytes are not disturbed, and the occupancy never exceeds FIFO_DEPTH.
- R10: While reset is held, `txd` is high, `tx_ready` is low, `rx_valid` is low and `cts_out` is high. `tx_ready` rises within a few cycles after release when `cts_in` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | DATA_BITS | Byte to send |
| tx_valid | input | 1 | Byte to send is present |
| tx_ready | output | 1 | Transmitter takes the byte this cycle |
| rx_data | output | DATA_BITS | Oldest received byte |
| rx_frame_err | output | 1 | Oldest byte had a low stop bit |
| rx_valid | output | 1 | A received byte is available |
| rx_ready | input | 1 | Consumer takes the byte this cycle |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line, asynchronous |
| cts_in | input | 1 | Peer permits transmission when high |
| cts_out | output | 1 | This side permits the peer to send when high |

## Verification
Two pairs of events can land in the same cycle. The first pair is the peer's permission falling while a byte waits at the transmit port. The bench provokes this by toggling the peer's CTS at random intervals during looped-back traffic. Each start bit is then judged against a count of how long `cts_in` has been low, and every frame is judged bit by bit at both edges of every bit period. The second pair is a byte entering the receive FIFO in the same cycle as the consumer removes one. A randomly stalled consumer provokes this, and it is judged by in-order delivery against a scoreboard and by directed `cts_out` checks at fixed occupancies.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // Clocks per bit, rounded to the nearest whole clock.
    function automatic int unsigned clks_per_bit(int unsigned clk_hz, int unsigned baud);
        return (clk_hz + baud / 2) / baud;
    endfunction

endpackage

// File: rtl/uart_fc_sync.sv
module uart_fc_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
    import uart_fc_pkg::*;
#(
    parameter int CPB       = 48,
    parameter int DATA_BITS = 8,
    parameter int STOP_BITS = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cts_ok,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 valid,
    output logic                 ready,
    output logic                 txd
);
    localparam int CW = $clog2(CPB);
    localparam int BW = $clog2(DATA_BITS + STOP_BITS + 1);

    tx_state_e              state, state_nxt;
    logic [CW-1:0]          cnt;
    logic [DATA_BITS-1:0]   shreg;
    logic [BW-1:0]          bitn;
    logic                   tick, accept, last_data, last_stop;

    assign tick      = (cnt == '0);
    assign accept    = (state == TX_IDLE) && valid && cts_ok;
    assign last_data = (bitn == BW'(DATA_BITS - 1));
    assign last_stop = (bitn == BW'(STOP_BITS - 1));

    always_comb begin
        state_nxt = state;
        unique case (state)
            TX_IDLE:  if (accept)              state_nxt = TX_START;
            TX_START: if (tick)                state_nxt = TX_DATA;
            TX_DATA:  if (tick && last_data)   state_nxt = TX_STOP;
            TX_STOP:  if (tick && last_stop)   state_nxt = TX_IDLE;
            default:                           state_nxt = TX_IDLE;
        endcase
    end

    // State register and bit timing: a bit ends when cnt reaches zero,
    // and the reload value CPB-1 gives exactly CPB clocks per bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
            shreg <= '0;
            bitn  <= '0;
        end else begin
            state <= state_nxt;
            if (accept) begin
                cnt   <= CW'(CPB - 1);
                shreg <= data;
                bitn  <= '0;
            end else if (state != TX_IDLE) begin
                if (tick) begin
                    cnt <= CW'(CPB - 1);
                    if (state == TX_DATA) shreg <= shreg >> 1;
                    if (state_nxt != state)     bitn <= '0;
                    else if (state != TX_START) bitn <= bitn + 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    always_comb begin
        ready = (state == TX_IDLE) && cts_ok;
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
    import uart_fc_pkg::*;
#(
    parameter int CPB       = 48,
    parameter int DATA_BITS = 8,
    parameter int STOP_BITS = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxs,
    output logic                 push,
    output logic [DATA_BITS-1:0] pdata,
    output logic                 perr
);
    localparam int CW   = $clog2(CPB);
    localparam int BW   = $clog2(DATA_BITS + STOP_BITS + 1);
    localparam int HALF = CPB / 2;

    rx_state_e              state, state_nxt;
    logic [CW-1:0]          cnt;
    logic [DATA_BITS-1:0]   sh;
    logic [BW-1:0]          bitn;
    logic                   prev, err_q;
    logic                   tick, fall, last_data, last_stop;

    assign tick      = (cnt == '0);
    assign fall      = prev && !rxs;
    assign last_data = (bitn == BW'(DATA_BITS - 1));
    assign last_stop = (bitn == BW'(STOP_BITS - 1));

    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_IDLE:  if (fall)               state_nxt = RX_START;
            RX_START: if (tick)               state_nxt = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && last_data)  state_nxt = RX_STOP;
            RX_STOP:  if (tick && last_stop)  state_nxt = RX_IDLE;
            default:                          state_nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            cnt   <= '0;
            sh    <= '0;
            bitn  <= '0;
            prev  <= 1'b1;
            err_q <= 1'b0;
        end else begin
            state <= state_nxt;
            prev  <= rxs;
            if (state == RX_IDLE) begin
                if (fall) begin
                    cnt   <= CW'(HALF - 1);
                    bitn  <= '0;
                    err_q <= 1'b0;
                end
            end else if (tick) begin
                cnt <= CW'(CPB - 1);
                if (state == RX_DATA) sh <= DATA_BITS'({rxs, sh} >> 1);
                if (state == RX_STOP && !rxs) err_q <= 1'b1;
                if (state_nxt != state)     bitn <= '0;
                else if (state != RX_START) bitn <= bitn + 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        push  = (state == RX_STOP) && tick && last_stop;
        pdata = sh;
        perr  = err_q | !rxs;
    end
endmodule

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [W-1:0]    wdata,
    input  logic            pop,
    output logic [W-1:0]    rdata,
    output logic [CNTW-1:0] count,
    output logic            full,
    output logic            empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CNTW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_fc.sv
module uart_fc
    import uart_fc_pkg::*;
#(
    parameter int CLK_HZ     = 24_000_000,
    parameter int BAUD       = 500_000,
    parameter int DATA_BITS  = 8,
    parameter int STOP_BITS  = 1,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_frame_err,
    output logic                 rx_valid,
    input  logic                 rx_ready,
    output logic                 txd,
    input  logic                 rxd,
    input  logic                 cts_in,
    output logic                 cts_out
);
    localparam int CPB  = int'(clks_per_bit(CLK_HZ, BAUD));
    localparam int CNTW = $clog2(FIFO_DEPTH + 1);

    logic                 cts_ok, rxs;
    logic                 rx_push, rx_perr;
    logic [DATA_BITS-1:0] rx_pdata;
    logic [DATA_BITS:0]   head;
    logic [CNTW-1:0]      fifo_cnt;
    logic                 fifo_full, fifo_empty;

    uart_fc_sync #(.RST_VAL(1'b0)) u_cts_sync (
        .clk(clk), .rst_n(rst_n), .d(cts_in), .q(cts_ok)
    );

    uart_fc_sync #(.RST_VAL(1'b1)) u_rxd_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxs)
    );

    uart_fc_tx #(.CPB(CPB), .DATA_BITS(DATA_BITS), .STOP_BITS(STOP_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n), .cts_ok(cts_ok),
        .data(tx_data), .valid(tx_valid), .ready(tx_ready), .txd(txd)
    );

    uart_fc_rx #(.CPB(CPB), .DATA_BITS(DATA_BITS), .STOP_BITS(STOP_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .rxs(rxs),
        .push(rx_push), .pdata(rx_pdata), .perr(rx_perr)
    );

    uart_fc_fifo #(.W(DATA_BITS + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata({rx_perr, rx_pdata}),
        .pop(rx_valid && rx_ready), .rdata(head),
        .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
    );

    assign rx_valid     = !fifo_empty;
    assign rx_data      = head[DATA_BITS-1:0];
    assign rx_frame_err = head[DATA_BITS];
    assign cts_out      = (fifo_cnt <= CNTW'(FIFO_DEPTH - 2));
endmodule

// File: rtl/uart_fc_chk.sv
module uart_fc_chk
    import uart_fc_pkg::*;
#(
    parameter int CLK_HZ     = 24_000_000,
    parameter int BAUD       = 500_000,
    parameter int DATA_BITS  = 8,
    parameter int FIFO_DEPTH = 4,
    localparam int CPB  = int'(clks_per_bit(CLK_HZ, BAUD)),
    localparam int CNTW = $clog2(FIFO_DEPTH + 1),
    localparam int PW   = $clog2(CPB + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 txd,
    input logic                 tx_valid,
    input logic                 tx_ready,
    input logic                 rx_valid,
    input logic                 rx_ready,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_frame_err,
    input logic [CNTW-1:0]      fifo_cnt
);
    // Bit phase counted from each accepted byte.
    logic [PW-1:0] ph;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    ph <= '0;
        else if (tx_valid && tx_ready) ph <= PW'(1);
        else if (ph == PW'(CPB - 1))   ph <= '0;
        else                           ph <= ph + 1'b1;
    end

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);

    // R2
    bit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> (ph == PW'(1)));

    // R3
    start_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !txd);

    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_frame_err)));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNTW'(FIFO_DEPTH));
endmodule

bind uart_fc uart_fc_chk #(
    .CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_BITS(DATA_BITS), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .fifo_cnt(fifo_cnt)
);

// File: tb/tb_uart_fc.sv
`timescale 1ns/1ps
module tb_uart_fc;
    localparam int CPB   = 48;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_frame_err, rx_valid;
    logic       rx_ready = 1'b0;
    logic       txd, rxd, cts_in, cts_out;
    logic       inj = 1'b0, rxd_drv = 1'b1;
    logic       gate = 1'b1, honor = 1'b0, rand_phase = 1'b0;

    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    assign rxd    = inj ? rxd_drv : txd;
    assign cts_in = gate & (honor ? cts_out : 1'b1);

    uart_fc dut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_frame_err(rx_frame_err),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .txd(txd), .rxd(rxd),
        .cts_in(cts_in), .cts_out(cts_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic frame_bit(input logic [7:0] b, input int idx);
        if (idx == 0) return 1'b0;
        if (idx <= 8) return b[idx-1];
        return 1'b1;
    endfunction

    // Handshake capture
    logic [7:0] mon_q[$];
    logic [7:0] sb_q[$];
    always @(posedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            mon_q.push_back(tx_data);
            if (rand_phase) sb_q.push_back(tx_data);
        end
    end

    // Consecutive edges with cts_in low
    int cts_low_run = 0;
    always @(posedge clk) cts_low_run <= cts_in ? 0 : cts_low_run + 1;

    // Line monitor: checks both ends of every bit period
    bit         mon_act = 0, mon_bad = 0;
    int         mon_n = 0, frames_seen = 0;
    logic [7:0] mon_byte = 8'h00;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mon_act && txd == 1'b0) begin
                mon_act = 1; mon_n = 0; mon_bad = 0; frames_seen++;
                mon_byte = (mon_q.size() != 0) ? mon_q.pop_front() : 8'h00;
                // R3: start only with recent permission
                chk(cts_low_run <= 2, "R3 start window", cts_low_run, 2);
            end
            if (mon_act) begin
                if (((mon_n % CPB) == 0 || (mon_n % CPB) == CPB - 1) &&
                    txd !== frame_bit(mon_byte, mon_n / CPB)) mon_bad = 1;
                mon_n++;
                if (mon_n == 10 * CPB) begin
                    mon_act = 0;
                    // R1 and R2: format and exact bit period
                    chk(!mon_bad, "R1 R2 frame shape", mon_bad, 0);
                end
            end
        end
    end

    // Random consumer and scoreboard (R6)
    always @(negedge clk) if (rand_phase) rx_ready = ($urandom_range(0, 3) != 0);
    int tog = 0;
    always @(negedge clk) begin
        if (rand_phase) begin
            if (tog == 0) begin
                gate = ($urandom_range(0, 3) != 0);
                tog  = $urandom_range(20, 400);
            end else tog--;
        end
    end
    always @(posedge clk) begin
        if (rand_phase && rx_valid && rx_ready) begin
            logic [7:0] e;
            e = (sb_q.size() != 0) ? sb_q.pop_front() : 8'hxx;
            chk(rx_data === e && !rx_frame_err, "R6 order", {rx_frame_err, rx_data}, e);
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk); tx_data = b; tx_valid = 1'b1;
        forever begin
            @(posedge clk);
            if (tx_ready) break;
        end
        @(negedge clk); tx_valid = 1'b0;
    endtask

    task automatic pop_expect(input logic [7:0] e, input logic err, input string req);
        @(negedge clk);
        chk(rx_valid && rx_data == e && rx_frame_err == err, req,
            {rx_valid, rx_frame_err, rx_data}, {1'b1, err, e});
        rx_ready = 1'b1;
        @(negedge clk); rx_ready = 1'b0;
    endtask

    task automatic send_raw(input logic [7:0] b, input logic stopb);
        for (int i = 0; i < 10; i++) begin
            rxd_drv = (i == 9) ? stopb : frame_bit(b, i);
            repeat (CPB) @(negedge clk);
        end
        rxd_drv = 1'b1;
        repeat (CPB) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(txd == 1 && tx_ready == 0 && rx_valid == 0 && cts_out == 1, "R10 reset",
            {txd, tx_ready, rx_valid, cts_out}, 4'b1001);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(tx_ready == 1, "R10 ready after reset", tx_ready, 1);

        // FIFO fill with consumer stalled (R8, R9)
        send(8'h11); repeat (560) @(negedge clk);
        send(8'h22); repeat (560) @(negedge clk);
        chk(cts_out == 1, "R8 two stored", cts_out, 1);
        send(8'h33); repeat (560) @(negedge clk);
        chk(cts_out == 0, "R8 three stored", cts_out, 0);
        send(8'h44); repeat (560) @(negedge clk);
        send(8'h55); repeat (560) @(negedge clk);
        pop_expect(8'h11, 1'b0, "R6 first");
        chk(cts_out == 0, "R8 after one pop", cts_out, 0);
        pop_expect(8'h22, 1'b0, "R6 second");
        chk(cts_out == 1, "R8 after two pops", cts_out, 1);
        pop_expect(8'h33, 1'b0, "R9 third kept");
        pop_expect(8'h44, 1'b0, "R9 fourth kept");
        @(negedge clk);
        chk(rx_valid == 0, "R9 overflow byte dropped", rx_valid, 0);

        // CTS held low blocks a start (R3)
        begin
            int f0;
            gate = 1'b0;
            repeat (5) @(negedge clk);
            f0 = frames_seen;
            tx_data = 8'h3C; tx_valid = 1'b1;
            repeat (300) @(negedge clk);
            chk(frames_seen == f0 && tx_ready == 0 && txd == 1, "R3 held by cts",
                frames_seen - f0, 0);
            gate = 1'b1;
            forever begin
                @(posedge clk);
                if (tx_ready) break;
            end
            @(negedge clk); tx_valid = 1'b0;
            // R4: drop permission mid-character, offer another byte
            repeat (100) @(negedge clk);
            gate = 1'b0;
            tx_data = 8'h81; tx_valid = 1'b1;
            repeat (700) @(negedge clk);
            chk(frames_seen == f0 + 1, "R4 no new start", frames_seen - f0, 1);
            pop_expect(8'h3C, 1'b0, "R4 finished byte");
            gate = 1'b1;
            forever begin
                @(posedge clk);
                if (tx_ready) break;
            end
            @(negedge clk); tx_valid = 1'b0;
            repeat (560) @(negedge clk);
            pop_expect(8'h81, 1'b0, "R4 resumed byte");
        end

        // Injected frames: framing error and start glitch (R7, R5)
        inj = 1'b1;
        send_raw(8'hA5, 1'b0);
        pop_expect(8'hA5, 1'b1, "R7 low stop");
        send_raw(8'h96, 1'b1);
        pop_expect(8'h96, 1'b0, "R7 good stop");
        rxd_drv = 1'b0;
        repeat (10) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (600) @(negedge clk);
        chk(rx_valid == 0, "R5 glitch rejected", rx_valid, 0);
        inj = 1'b0;

        // Random looped-back traffic with toggling peer CTS (R3, R4, R6)
        honor = 1'b1;
        rand_phase = 1'b1;
        for (int i = 0; i < 40; i++) begin
            send(8'($urandom()));
            repeat ($urandom_range(0, 100)) @(negedge clk);
        end
        for (int i = 0; i < 8000 && (sb_q.size() != 0 || mon_act); i++) @(negedge clk);
        rand_phase = 1'b0;
        gate = 1'b1;
        @(negedge clk); rx_ready = 1'b0;
        chk(sb_q.size() == 0, "R6 all delivered", sb_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule